// File: doc/BRIEF.md
# Least-Attained-Service Thread Ranking Scheduler

This block picks one request per cycle from a shared memory request buffer. Its preference goes to threads that have drawn little memory service over long stretches of time. Time is cut into quanta of programmable length, and a per-thread counter adds up the cycles in which banks are busy serving that thread. At each quantum boundary a smoothed history total is folded forward for every thread, using only shifts and adds. The threads are then re-ranked in one sequential pass, so that a lighter history gives a better rank.

The ranking is frozen between passes. It is also exposed on a port, so that other controllers can adopt the same order. The grant decision is combinational. A request whose age has reached a programmable starvation limit beats everything else. Below that come the owning thread's rank, then an open-row hit, then age, and finally the lowest buffer index.

Top module: `lasq_sched`

## Requirements
- R1: A quantum boundary occurs on every `quantum_len`-th rising clock edge counted from reset release. Service observed on the boundary edge is credited to the new quantum.
- R2: Each thread's quantum counter adds, per edge, the number of banks with `svc_busy[b]` set whose `svc_thr` field equals that thread. The counter saturates at 2^AS_W-1.
- R3: At a boundary, each thread's total becomes T - (T >> s) + (C >> s), saturating at 2^TOT_W-1, where T is the old total, C the finished quantum count and s is `alpha_sh`. A larger s weights history more.
- R4: In the ranking, rank 0 goes to the smallest total. Equal totals are ordered by lower thread index. Field t of `rank_vec` (bits t*TW +: TW) holds thread t's rank, and the ranks always form a permutation.
- R5: After reset, thread t has rank t. A new ranking appears on `rank_vec` exactly NTHR edges after the boundary that started it, and it is unchanged at all other times.
- R6: A valid entry whose age is at least `starve_age` wins over any entry that is not starved.
- R7: Among entries of equal starved status, the entry whose thread has the lower rank value wins.
- R8: Next, an entry whose bank has `open_vld` set and whose row equals `open_row` of that bank wins over a miss.
- R9: Next, the larger age wins, then the lower entry index. `grant_vld` is 0 exactly when no entry is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| quantum_len | input | QW | Quantum length in cycles |
| alpha_sh | input | SHW | History weight shift s; alpha = 1 - 2^-s |
| starve_age | input | AGE_W | Age at or above which an entry is starved |
| req_valid | input | NENT | Entry valid flags |
| req_thr | input | NENT*TW | Thread of entry i at [i*TW +: TW] |
| req_bank | input | NENT*BW | Bank of entry i at [i*BW +: BW] |
| req_row | input | NENT*ROW_W | Row of entry i at [i*ROW_W +: ROW_W] |
| req_age | input | NENT*AGE_W | Saturating age of entry i at [i*AGE_W +: AGE_W] |
| open_vld | input | NBANK | Bank b has an open row |
| open_row | input | NBANK*ROW_W | Open row of bank b at [b*ROW_W +: ROW_W] |
| svc_busy | input | NBANK | Bank b is serving a request this cycle |
| svc_thr | input | NBANK*TW | Thread served by bank b at [b*TW +: TW] |
| grant_vld | output | 1 | A request is granted |
| grant_idx | output | EW | Index of the granted entry |
| rank_vec | output | NTHR*TW | Current rank of each thread |

## Verification
Two functions can fall in the same cycle here. On a quantum boundary edge the quantum counter must both hand its finished value to the total update and start the new quantum with that edge's service. The bench drives random bank service on every edge, boundary edges included, and a bench-side arithmetic model of R1 to R3 predicts the totals. Any misplaced cycle of credit shows up as a wrong ranking on `rank_vec`, and the bench compares `rank_vec` on every cycle, including the NTHR-cycle window in which the old ranking must still hold. The grant is checked on each of those cycles as well, so the starvation override, rank, row hit and age ordering are all judged against the exact ranking in force during and after a commit.

// File: rtl/lasq_pkg.sv
package lasq_pkg;
  typedef enum logic [0:0] {RK_IDLE, RK_PASS} rk_state_e;
endpackage

// File: rtl/lasq_service.sv
module lasq_service #(
  parameter int NTHR  = 4,
  parameter int NBANK = 4,
  parameter int TW    = 2,
  parameter int AS_W  = 16,
  parameter int TOT_W = 16,
  parameter int QW    = 24,
  parameter int SHW   = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [QW-1:0]         quantum_len,
  input  logic [SHW-1:0]        alpha_sh,
  input  logic [NBANK-1:0]      svc_busy,
  input  logic [NBANK*TW-1:0]   svc_thr,
  output logic                  tick,
  output logic [NTHR*TOT_W-1:0] tot_flat
);
  localparam int IW = $clog2(NBANK + 1);

  logic [QW-1:0]    qcnt_q, qcnt_d;
  logic [IW-1:0]    inc   [NTHR];
  logic [AS_W-1:0]  cnt_q [NTHR];
  logic [AS_W-1:0]  cnt_d [NTHR];
  logic [TOT_W-1:0] tot_q [NTHR];
  logic [TOT_W-1:0] tot_d [NTHR];

  // quantum timer
  always_comb begin
    tick   = ({1'b0, qcnt_q} + (QW+1)'(1)) >= {1'b0, quantum_len};
    qcnt_d = tick ? '0 : qcnt_q + QW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) qcnt_q <= '0;
    else        qcnt_q <= qcnt_d;
  end

  // per-thread busy-bank count for this cycle
  always_comb begin
    for (int t = 0; t < NTHR; t++) begin
      inc[t] = '0;
      for (int b = 0; b < NBANK; b++) begin
        if (svc_busy[b] && (svc_thr[b*TW +: TW] == TW'(t))) inc[t] = inc[t] + IW'(1);
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NTHR; g++) begin : g_thr
      logic [AS_W:0]  csum;
      logic [TOT_W-1:0] keep;
      logic [AS_W-1:0]  part;
      logic [TOT_W:0]   tsum;

      always_comb begin
        csum     = {1'b0, cnt_q[g]} + (AS_W+1)'(inc[g]);
        cnt_d[g] = tick ? AS_W'(inc[g]) : (csum[AS_W] ? '1 : csum[AS_W-1:0]);
        keep     = tot_q[g] - (tot_q[g] >> alpha_sh);
        part     = cnt_q[g] >> alpha_sh;
        tsum     = (TOT_W+1)'(keep) + (TOT_W+1)'(part);
        tot_d[g] = tsum[TOT_W] ? '1 : tsum[TOT_W-1:0];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q[g] <= '0;
          tot_q[g] <= '0;
        end else begin
          cnt_q[g] <= cnt_d[g];
          if (tick) tot_q[g] <= tot_d[g];
        end
      end

      assign tot_flat[g*TOT_W +: TOT_W] = tot_q[g];

      // R2: the counter restarts from the boundary cycle's own service
      a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q[g] == AS_W'($past(inc[g]))));
      // R2: inside a quantum the counter never wraps downward
      a_r2_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (cnt_q[g] >= $past(cnt_q[g])));
      // R3: totals move only on a boundary
      a_r3_total_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(tot_q[g]));
    end
  endgenerate

  // R1: the timer stays inside the programmed quantum
  a_r1_timer_range: assert property (@(posedge clk) disable iff (!rst_n)
    (quantum_len != '0) |-> (qcnt_q < quantum_len));
endmodule

// File: rtl/lasq_ranker.sv
module lasq_ranker
  import lasq_pkg::*;
#(
  parameter int NTHR  = 4,
  parameter int TW    = 2,
  parameter int TOT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [NTHR*TOT_W-1:0] tot_flat,
  output logic [NTHR*TW-1:0]    rank_flat
);
  rk_state_e      st_q, st_d;
  logic [TW-1:0]  step_q, step_d;
  logic [TW-1:0]  shadow_q [NTHR];
  logic [TW-1:0]  rank_q   [NTHR];
  logic [TW-1:0]  rank_d   [NTHR];
  logic [TOT_W-1:0] cur;
  logic [TW-1:0]  pos;
  logic           last, commit;
  logic [NTHR-1:0] used;

  // position of thread step_q among all totals
  always_comb begin
    cur = tot_flat[step_q*TOT_W +: TOT_W];
    pos = '0;
    for (int j = 0; j < NTHR; j++) begin
      if ((tot_flat[j*TOT_W +: TOT_W] < cur) ||
          ((tot_flat[j*TOT_W +: TOT_W] == cur) && (TW'(j) < step_q)))
        pos = pos + TW'(1);
    end
  end

  always_comb begin
    last   = (step_q == TW'(NTHR-1));
    commit = (st_q == RK_PASS) && last && !start;
    st_d   = st_q;
    step_d = step_q;
    if (start) begin
      st_d   = RK_PASS;
      step_d = '0;
    end else if (st_q == RK_PASS) begin
      step_d = step_q + TW'(1);
      if (last) st_d = RK_IDLE;
    end
    for (int t = 0; t < NTHR; t++) rank_d[t] = shadow_q[t];
    rank_d[step_q] = pos;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RK_IDLE;
      step_q <= '0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < NTHR; t++) begin
        shadow_q[t] <= TW'(t);
        rank_q[t]   <= TW'(t);
      end
    end else begin
      if ((st_q == RK_PASS) && !start) shadow_q[step_q] <= pos;
      if (commit) begin
        for (int t = 0; t < NTHR; t++) rank_q[t] <= rank_d[t];
      end
    end
  end

  always_comb begin
    used = '0;
    for (int t = 0; t < NTHR; t++) begin
      rank_flat[t*TW +: TW] = rank_q[t];
      used[rank_q[t]] = 1'b1;
    end
  end

  // R4: every rank value is held by exactly one thread
  a_r4_permutation: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(used) == NTHR);
  // R5: the published ranking only moves at the end of a pass
  a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RK_IDLE) |=> $stable(rank_flat));
endmodule

// File: rtl/lasq_pick.sv
module lasq_pick #(
  parameter int NENT  = 8,
  parameter int NBANK = 4,
  parameter int NTHR  = 4,
  parameter int TW    = 2,
  parameter int BW    = 2,
  parameter int ROW_W = 8,
  parameter int AGE_W = 8,
  parameter int EW    = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [AGE_W-1:0]       starve_age,
  input  logic [NENT-1:0]        req_valid,
  input  logic [NENT*TW-1:0]     req_thr,
  input  logic [NENT*BW-1:0]     req_bank,
  input  logic [NENT*ROW_W-1:0]  req_row,
  input  logic [NENT*AGE_W-1:0]  req_age,
  input  logic [NBANK-1:0]       open_vld,
  input  logic [NBANK*ROW_W-1:0] open_row,
  input  logic [NTHR*TW-1:0]     rank_flat,
  output logic                   grant_vld,
  output logic [EW-1:0]          grant_idx
);
  localparam int KW = 1 + TW + 1 + AGE_W;

  logic [KW-1:0]   key [NENT];
  logic [NENT-1:0] starved;
  logic [KW-1:0]   best;

  genvar g;
  generate
    for (g = 0; g < NENT; g++) begin : g_ent
      logic [TW-1:0]    thr;
      logic [BW-1:0]    bnk;
      logic [AGE_W-1:0] age;
      logic             hit;
      always_comb begin
        thr        = req_thr[g*TW +: TW];
        bnk        = req_bank[g*BW +: BW];
        age        = req_age[g*AGE_W +: AGE_W];
        hit        = open_vld[bnk] && (open_row[bnk*ROW_W +: ROW_W] == req_row[g*ROW_W +: ROW_W]);
        starved[g] = age >= starve_age;
        key[g]     = {starved[g], TW'(NTHR-1) - rank_flat[thr*TW +: TW], hit, age};
      end
    end
  endgenerate

  // strict compare keeps the lowest index on a full tie
  always_comb begin
    grant_vld = 1'b0;
    grant_idx = '0;
    best      = '0;
    for (int i = 0; i < NENT; i++) begin
      if (req_valid[i] && (!grant_vld || (key[i] > best))) begin
        grant_vld = 1'b1;
        grant_idx = EW'(i);
        best      = key[i];
      end
    end
  end

  // R9: a grant always points at a valid entry
  a_r9_grant_valid: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> req_valid[grant_idx]);
  // R6: if any valid entry is starved, the winner is starved
  a_r6_starve_first: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && ((req_valid & starved) != '0)) |-> starved[grant_idx]);
endmodule

// File: rtl/lasq_sched.sv
module lasq_sched #(
  parameter int NTHR  = 4,
  parameter int NENT  = 8,
  parameter int NBANK = 4,
  parameter int ROW_W = 8,
  parameter int AGE_W = 8,
  parameter int QW    = 24,
  parameter int AS_W  = 16,
  parameter int TOT_W = 16,
  parameter int SHW   = 3,
  localparam int TW   = $clog2(NTHR),
  localparam int BW   = $clog2(NBANK),
  localparam int EW   = $clog2(NENT)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [QW-1:0]          quantum_len,
  input  logic [SHW-1:0]         alpha_sh,
  input  logic [AGE_W-1:0]       starve_age,
  input  logic [NENT-1:0]        req_valid,
  input  logic [NENT*TW-1:0]     req_thr,
  input  logic [NENT*BW-1:0]     req_bank,
  input  logic [NENT*ROW_W-1:0]  req_row,
  input  logic [NENT*AGE_W-1:0]  req_age,
  input  logic [NBANK-1:0]       open_vld,
  input  logic [NBANK*ROW_W-1:0] open_row,
  input  logic [NBANK-1:0]       svc_busy,
  input  logic [NBANK*TW-1:0]    svc_thr,
  output logic                   grant_vld,
  output logic [EW-1:0]          grant_idx,
  output logic [NTHR*TW-1:0]     rank_vec
);
  logic                  tick;
  logic [NTHR*TOT_W-1:0] tot_flat;

  lasq_service #(
    .NTHR(NTHR), .NBANK(NBANK), .TW(TW), .AS_W(AS_W),
    .TOT_W(TOT_W), .QW(QW), .SHW(SHW)
  ) u_service (
    .clk(clk), .rst_n(rst_n), .quantum_len(quantum_len), .alpha_sh(alpha_sh),
    .svc_busy(svc_busy), .svc_thr(svc_thr), .tick(tick), .tot_flat(tot_flat)
  );

  lasq_ranker #(.NTHR(NTHR), .TW(TW), .TOT_W(TOT_W)) u_ranker (
    .clk(clk), .rst_n(rst_n), .start(tick), .tot_flat(tot_flat), .rank_flat(rank_vec)
  );

  lasq_pick #(
    .NENT(NENT), .NBANK(NBANK), .NTHR(NTHR), .TW(TW), .BW(BW),
    .ROW_W(ROW_W), .AGE_W(AGE_W), .EW(EW)
  ) u_pick (
    .clk(clk), .rst_n(rst_n), .starve_age(starve_age), .req_valid(req_valid),
    .req_thr(req_thr), .req_bank(req_bank), .req_row(req_row), .req_age(req_age),
    .open_vld(open_vld), .open_row(open_row), .rank_flat(rank_vec),
    .grant_vld(grant_vld), .grant_idx(grant_idx)
  );
endmodule

// File: tb/tb_lasq_sched.sv
`timescale 1ns/1ps
module tb_lasq_sched;
  localparam int NTHR = 4, NENT = 8, NBANK = 4, ROW_W = 4, AGE_W = 5;
  localparam int QW = 8, AS_W = 6, TOT_W = 6, SHW = 3;
  localparam int TW = 2, BW = 2, EW = 3;
  localparam int Q = 24;
  localparam int CMAX = (1 << AS_W) - 1;
  localparam int TMAX = (1 << TOT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [QW-1:0]          quantum_len = QW'(Q);
  logic [SHW-1:0]         alpha_sh = '0;
  logic [AGE_W-1:0]       starve_age = AGE_W'(28);
  logic [NENT-1:0]        req_valid = '0;
  logic [NENT*TW-1:0]     req_thr = '0;
  logic [NENT*BW-1:0]     req_bank = '0;
  logic [NENT*ROW_W-1:0]  req_row = '0;
  logic [NENT*AGE_W-1:0]  req_age = '0;
  logic [NBANK-1:0]       open_vld = '0;
  logic [NBANK*ROW_W-1:0] open_row = '0;
  logic [NBANK-1:0]       svc_busy = '0;
  logic [NBANK*TW-1:0]    svc_thr = '0;
  logic                   grant_vld;
  logic [EW-1:0]          grant_idx;
  logic [NTHR*TW-1:0]     rank_vec;

  int total = 0, bad = 0;
  bit done = 0;

  lasq_sched #(
    .NTHR(NTHR), .NENT(NENT), .NBANK(NBANK), .ROW_W(ROW_W), .AGE_W(AGE_W),
    .QW(QW), .AS_W(AS_W), .TOT_W(TOT_W), .SHW(SHW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .quantum_len(quantum_len), .alpha_sh(alpha_sh),
    .starve_age(starve_age), .req_valid(req_valid), .req_thr(req_thr),
    .req_bank(req_bank), .req_row(req_row), .req_age(req_age),
    .open_vld(open_vld), .open_row(open_row), .svc_busy(svc_busy),
    .svc_thr(svc_thr), .grant_vld(grant_vld), .grant_idx(grant_idx),
    .rank_vec(rank_vec)
  );

  always #2 clk = ~clk;

  // arithmetic model of R1..R5
  int tot_m [NTHR];
  int cnt_m [NTHR];
  int rank_exp [NTHR];
  int rank_nxt [NTHR];
  int ecount, pend;

  always @(posedge clk or negedge rst_n) begin : model
    int inc [NTHR];
    if (!rst_n) begin
      for (int t = 0; t < NTHR; t++) begin
        tot_m[t] = 0; cnt_m[t] = 0; rank_exp[t] = t; rank_nxt[t] = t;
      end
      ecount = 0; pend = 0;
    end else begin
      for (int t = 0; t < NTHR; t++) inc[t] = 0;
      for (int b = 0; b < NBANK; b++)
        if (svc_busy[b]) inc[int'(svc_thr[b*TW +: TW])]++;
      ecount++;
      if (pend > 0) begin
        pend--;
        if (pend == 0) for (int t = 0; t < NTHR; t++) rank_exp[t] = rank_nxt[t];
      end
      if (ecount % Q == 0) begin
        for (int t = 0; t < NTHR; t++) begin
          int v;
          v = tot_m[t] - (tot_m[t] >> alpha_sh) + (cnt_m[t] >> alpha_sh);
          tot_m[t] = (v > TMAX) ? TMAX : v;
          cnt_m[t] = inc[t];
        end
        for (int t = 0; t < NTHR; t++) begin
          rank_nxt[t] = 0;
          for (int j = 0; j < NTHR; j++)
            if (tot_m[j] < tot_m[t] || (tot_m[j] == tot_m[t] && j < t)) rank_nxt[t]++;
        end
        pend = NTHR;
      end else begin
        for (int t = 0; t < NTHR; t++)
          cnt_m[t] = (cnt_m[t] + inc[t] > CMAX) ? CMAX : cnt_m[t] + inc[t];
      end
    end
  end

  function automatic int ent_key(int i);
    int thr, bnk, age, hit, st;
    thr = int'(req_thr[i*TW +: TW]);
    bnk = int'(req_bank[i*BW +: BW]);
    age = int'(req_age[i*AGE_W +: AGE_W]);
    hit = (open_vld[bnk] && open_row[bnk*ROW_W +: ROW_W] == req_row[i*ROW_W +: ROW_W]) ? 1 : 0;
    st  = (age >= int'(starve_age)) ? 1 : 0;
    return (st << 20) | ((NTHR - 1 - rank_exp[thr]) << 12) | (hit << 8) | age;
  endfunction

  task automatic check_rank(string tag);
    total++;
    for (int t = 0; t < NTHR; t++) begin
      if (int'(rank_vec[t*TW +: TW]) != rank_exp[t]) begin
        bad++;
        $display("FAIL %s thread %0d rank actual=%0d expected=%0d at edge %0d",
                 tag, t, rank_vec[t*TW +: TW], rank_exp[t], ecount);
        break;
      end
    end
  endtask

  task automatic check_grant();
    int best, bk, exp_v;
    best = -1; bk = -1;
    for (int i = 0; i < NENT; i++) begin
      if (req_valid[i] && (best < 0 || ent_key(i) > bk)) begin
        best = i; bk = ent_key(i);
      end
    end
    exp_v = (best >= 0) ? 1 : 0;
    total++;
    if (grant_vld != exp_v[0] || (exp_v == 1 && int'(grant_idx) != best)) begin
      bad++;
      $display("FAIL R6 R7 R8 R9 grant actual=%0d/%0d expected=%0d/%0d",
               grant_vld, grant_idx, exp_v, best);
    end
  endtask

  task automatic drive_random(int heavy);
    req_valid = NENT'($urandom);
    for (int i = 0; i < NENT; i++) begin
      req_thr[i*TW +: TW]       = TW'($urandom);
      req_bank[i*BW +: BW]      = BW'($urandom);
      req_row[i*ROW_W +: ROW_W] = ROW_W'($urandom % 3);
      req_age[i*AGE_W +: AGE_W] = AGE_W'($urandom);
    end
    open_vld = NBANK'($urandom);
    for (int b = 0; b < NBANK; b++) begin
      open_row[b*ROW_W +: ROW_W] = ROW_W'($urandom % 3);
      svc_busy[b] = ($urandom % 4) != 0;
      // bias service toward one thread so rankings separate
      svc_thr[b*TW +: TW] = (($urandom % 3) == 0) ? TW'($urandom) : TW'(heavy);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R5: reset state, identity ranking; R9: nothing valid, no grant
    #1;
    check_rank("R5 reset");
    total++;
    if (grant_vld !== 1'b0) begin
      bad++;
      $display("FAIL R9 reset grant_vld actual=%0b expected=0", grant_vld);
    end
    @(negedge clk);
    rst_n = 1'b1;
    for (int s = 0; s < 6; s++) begin
      alpha_sh = SHW'(s);
      for (int c = 0; c < 5 * Q; c++) begin
        @(negedge clk);
        drive_random((s + c / Q) % NTHR);
        #1;
        // R1 R2 R3 R4 R5: ranking derived from the modelled service history
        check_rank("R1 R2 R3 R4 R5");
        check_grant();
      end
    end
    // R6: heavy starvation sweep, lower threshold
    starve_age = AGE_W'(10);
    for (int c = 0; c < 3 * Q; c++) begin
      @(negedge clk);
      drive_random(c % NTHR);
      #1;
      check_rank("R4 R5");
      check_grant();
    end
    // R9: empty buffer after traffic
    @(negedge clk);
    req_valid = '0;
    #1;
    check_grant();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule